// File: doc/BRIEF.md
# Pipeline Register File with Same-Cycle Write Bypass

This block holds the general-purpose registers of a five-stage pipelined integer core. The decode stage uses two read ports, one for each source operand field of an instruction. Both ports are combinational: the data at the output follows the index at the input within the same cycle. The writeback stage drives the single write port with an enable, a destination index and the result value.

Inside the cycle, the block behaves as if the write happens in the first half and both reads happen in the second half. When a read port addresses the register that writeback is writing in that cycle, the port returns the incoming write data and not the stored value. An instruction three slots behind a producer therefore sees the result without a stall and without any forwarding path outside the register file. Index zero is hardwired to zero. Writes to it are dropped, and it never takes the bypass.

The asynchronous active-low reset clears every register. Its release is synchronised inside the block, so the first writes are accepted once the internal reset has come out of reset.

Top module: `gpr_bank_wbr`

## Requirements
- R1: Each read port is combinational. A change of `rd_a_idx` or `rd_b_idx` shows up on the matching data output in the same cycle, with no clock edge between them.
- R2: When `wr_en` is 1 at a rising edge and `wr_idx` is not 0, register `wr_idx` takes `wr_data`. Every later read of that index returns this value until the register is written again.
- R3: When `wr_en` is 0 at a rising edge, no register changes, whatever `wr_idx` and `wr_data` hold.
- R4: While `wr_en` is 1 and `wr_idx` equals a port's read index (not 0), that port outputs `wr_data` in the same cycle. This holds for port A, port B, or both at once.
- R5: While `wr_en` is 0, a read whose index equals `wr_idx` returns the stored value and not `wr_data`.
- R6: Index 0 always reads as 32'h0000_0000. A write to index 0 changes no register, and it is never bypassed to a port that reads index 0.
- R7: While `rst_n` is 0, every register holds zero, and both ports read zero for any index, even with a write applied. After `rst_n` rises, the internal reset releases on the second rising edge. Writes take effect from the third rising edge onward.
- R8: The two ports are independent. They may read two different registers, or the same register, in one cycle, and each returns that register's value.
- R9: The file holds 32 registers of 32 bits, indexed 0 to 31 by a 5-bit field. Indices 1 to 31 can each hold a distinct value at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| rd_a_idx | input | 5 | Register index of read port A (first source operand) |
| rd_a_data | output | 32 | Data of read port A |
| rd_b_idx | input | 5 | Register index of read port B (second source operand) |
| rd_b_data | output | 32 | Data of read port B |
| wr_en | input | 1 | Write enable from writeback |
| wr_idx | input | 5 | Destination register index |
| wr_data | input | 32 | Write data |

## Verification
The bench targets a read of the register being written in the same cycle, on each port and on both ports together. A design that wrote only at the edge would return the stale value there, one cycle too early. It also drives a matching index with `wr_en` low, which catches a bypass that ignores the enable and leaks `wr_data`. Writes and bypass attempts to index 0 would expose a design that stores into register zero or forwards to it. A fill of all 31 writable registers followed by a reset in mid-run shows any alias in the index decode, or a register that the reset misses.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned GPR_NREGS   = 32;
  localparam int unsigned GPR_WIDTH   = 32;
  localparam int unsigned GPR_SYNC_FF = 2;
endpackage

// File: rtl/gpr_rst_sync.sv
module gpr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int unsigned NREGS = 32,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [NREGS-1:0] wr_sel
);
  always_comb begin
    wr_sel = '0;
    if (wr_en && (wr_idx != '0)) begin
      wr_sel[wr_idx] = 1'b1;
    end
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREGS-1:0]           wr_sel,
  input  logic [DW-1:0]              wr_data,
  output logic [NREGS-1:0][DW-1:0]   file_q
);
  assign file_q[0] = '0;

  for (genvar i = 1; i < NREGS; i++) begin : g_reg
    logic [DW-1:0] slot_q;
    logic [DW-1:0] slot_d;
    logic          slot_ce;

    always_comb begin
      slot_ce = wr_sel[i];
      slot_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_ce) begin
        slot_q <= slot_d;
      end
    end

    assign file_q[i] = slot_q;

    // R7: every register is zero on the first edge out of reset
    p_clear_on_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (slot_q == '0));
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic [IDX_W-1:0]         rd_idx,
  input  logic [NREGS-1:0][DW-1:0] file_q,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DW-1:0]            wr_data,
  output logic [DW-1:0]            rd_data
);
  logic bypass_hit;

  always_comb begin
    bypass_hit = wr_en && (wr_idx == rd_idx) && (rd_idx != '0);
    rd_data    = bypass_hit ? wr_data : file_q[rd_idx];
  end
endmodule

// File: rtl/gpr_bank_wbr.sv
module gpr_bank_wbr
  import gpr_pkg::*;
#(
  parameter int unsigned NREGS   = GPR_NREGS,
  parameter int unsigned DW      = GPR_WIDTH,
  parameter int unsigned SYNC_FF = GPR_SYNC_FF,
  localparam int unsigned IDX_W  = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [DW-1:0]    rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]    rd_b_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data
);
  logic                     core_rst_n;
  logic                     wr_en_live;
  logic [NREGS-1:0]         wr_sel;
  logic [NREGS-1:0][DW-1:0] file_q;
  logic [IDX_W-1:0]         rd_idx_v  [2];
  logic [DW-1:0]            rd_data_v [2];

  gpr_rst_sync #(.STAGES(SYNC_FF)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  assign wr_en_live = wr_en & core_rst_n;

  gpr_wr_decode #(.NREGS(NREGS)) u_wr_decode (
    .wr_en  (wr_en_live),
    .wr_idx (wr_idx),
    .wr_sel (wr_sel)
  );

  gpr_store #(.NREGS(NREGS), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .file_q  (file_q)
  );

  assign rd_idx_v[0] = rd_a_idx;
  assign rd_idx_v[1] = rd_b_idx;

  for (genvar p = 0; p < 2; p++) begin : g_port
    gpr_read_port #(.NREGS(NREGS), .DW(DW)) u_port (
      .rd_idx  (rd_idx_v[p]),
      .file_q  (file_q),
      .wr_en   (wr_en_live),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_data (rd_data_v[p])
    );
  end

  assign rd_a_data = rd_data_v[0];
  assign rd_b_data = rd_data_v[1];

  // R4: same-cycle bypass on each port
  p_bypass_a_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && wr_idx != '0 && wr_idx == rd_a_idx) |-> (rd_a_data == wr_data));
  p_bypass_b_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && wr_idx != '0 && wr_idx == rd_b_idx) |-> (rd_b_data == wr_data));

  // R6: index zero reads zero on both ports
  p_zero_a_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_a_idx == '0) |-> (rd_a_data == '0));
  p_zero_b_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_b_idx == '0) |-> (rd_b_data == '0));

  // R2: a committed write is seen the following cycle
  p_commit_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && wr_idx != '0) |=>
      ((rd_a_idx != $past(wr_idx)) || (wr_en && wr_idx == rd_a_idx) ||
       (rd_a_data == $past(wr_data))));

  // R3: an idle cycle leaves a held read unchanged
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!wr_en) |=>
      ((rd_b_idx != $past(rd_b_idx)) || (wr_en && wr_idx == rd_b_idx) ||
       $stable(rd_b_data)));
endmodule

// File: tb/test_gpr_bank_wbr.sv
module test_gpr_bank_wbr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpr_bank_wbr i_gpr_bank_wbr (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  typedef struct packed {
    logic        we;
    logic [4:0]  widx;
    logic [31:0] wdat;
    logic [4:0]  aidx;
    logic [4:0]  bidx;
    logic [31:0] exp_a;
    logic [31:0] exp_b;
  } vec_t;

  // applied in order from an all-zero file
  localparam vec_t TBL [10] = '{
    '{1'b1, 5'd5,  32'hA5A5_0001, 5'd5,  5'd6,  32'hA5A5_0001, 32'h0000_0000}, // R4 bypass on A
    '{1'b0, 5'd5,  32'hFFFF_FFFF, 5'd5,  5'd5,  32'hA5A5_0001, 32'hA5A5_0001}, // R2 R5 R8
    '{1'b1, 5'd6,  32'h0000_1234, 5'd6,  5'd5,  32'h0000_1234, 32'hA5A5_0001}, // R4 R8
    '{1'b1, 5'd0,  32'hDEAD_BEEF, 5'd0,  5'd0,  32'h0000_0000, 32'h0000_0000}, // R6 no bypass
    '{1'b0, 5'd6,  32'h0000_0000, 5'd0,  5'd6,  32'h0000_0000, 32'h0000_1234}, // R6 R2
    '{1'b1, 5'd31, 32'h8000_0000, 5'd31, 5'd30, 32'h8000_0000, 32'h0000_0000}, // R4 top index
    '{1'b1, 5'd5,  32'h0000_0055, 5'd31, 5'd5,  32'h8000_0000, 32'h0000_0055}, // R4 on B
    '{1'b0, 5'd31, 32'h1111_1111, 5'd31, 5'd5,  32'h8000_0000, 32'h0000_0055}, // R3 R5
    '{1'b1, 5'd1,  32'hFFFF_FFFF, 5'd1,  5'd1,  32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R4 both ports
    '{1'b0, 5'd0,  32'h0000_0000, 5'd1,  5'd6,  32'hFFFF_FFFF, 32'h0000_1234}  // R2 R1
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h3C00_0000 ^ (i * 32'h0001_0203) ^ (i << 27);
  endfunction

  task automatic release_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    repeat (3) @(negedge clk);
    // R7: contents zero while in reset
    rd_a_idx = 5'd17; rd_b_idx = 5'd31; #2;
    check("R7 reset A", rd_a_data, 32'h0);
    check("R7 reset B", rd_b_data, 32'h0);
    release_reset();

    for (int k = 0; k < 10; k++) begin
      wr_en = TBL[k].we; wr_idx = TBL[k].widx; wr_data = TBL[k].wdat;
      rd_a_idx = TBL[k].aidx; rd_b_idx = TBL[k].bidx;
      #2;
      check($sformatf("R4/R2 vector %0d port A", k), rd_a_data, TBL[k].exp_a);
      check($sformatf("R4/R2 vector %0d port B", k), rd_b_data, TBL[k].exp_b);
      @(negedge clk);
    end
    wr_en = 1'b0;

    // R1: combinational read, index change without an edge
    rd_a_idx = 5'd6; #2;
    check("R1 comb A", rd_a_data, 32'h0000_1234);
    rd_a_idx = 5'd5; #2;
    check("R1 comb A retarget", rd_a_data, 32'h0000_0055);
    @(negedge clk);

    // R9: fill all writable registers
    for (int i = 1; i < 32; i++) begin
      wr_en = 1'b1; wr_idx = 5'(i); wr_data = pat(i);
      @(negedge clk);
    end
    wr_en = 1'b0;
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i); #2;
      check("R9 fill A", rd_a_data, (i == 0) ? 32'h0 : pat(i));
      check("R9 fill B", rd_b_data, (i == 31) ? 32'h0 : pat(31 - i));
      @(negedge clk);
    end

    // R6: write to zero then read it on the next cycle
    wr_en = 1'b1; wr_idx = 5'd0; wr_data = 32'hCAFE_F00D; rd_a_idx = 5'd0; rd_b_idx = 5'd2;
    @(negedge clk); wr_en = 1'b0; #2;
    check("R6 zero after write", rd_a_data, 32'h0);
    check("R6 neighbour intact", rd_b_data, pat(2));

    // R7: reset in mid-run, write attempted during reset
    @(negedge clk) rst_n = 1'b0;
    wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'h7777_7777;
    rd_a_idx = 5'd9; rd_b_idx = 5'd20; #2;
    check("R7 no bypass in reset", rd_a_data, 32'h0);
    check("R7 async clear", rd_b_data, 32'h0);
    @(negedge clk); wr_en = 1'b0;
    release_reset();
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i); rd_b_idx = 5'(i); #2;
      check("R7 cleared A", rd_a_data, 32'h0);
      check("R7 cleared B", rd_b_data, 32'h0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule